// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank

This block is a register-mapped bank of sixteen general-purpose pins. Software reaches it through a plain 32-bit register port: an 8-bit byte offset, a write strobe and write data. Read data is combinational on the offset, with no wait states. Each pin has a direction bit and an output value. Each input is brought into the clock domain by a two-flop synchroniser. After that, an edge detector watches the input for a rising edge, a falling edge, both, or neither, as chosen by a 2-bit trigger field for that pin.

A detected edge latches a pending bit. Software clears a pending bit by writing 1 to it. The bank combines the pending bits into two outputs: `irq` counts only pins with interrupt enable set, and `wake` counts only pins with wakeup enable set. The data-out, interrupt-enable and wakeup-enable registers each have two extra alias offsets. Writing 1 to a bit at an alias sets that bit or clears it, so one pin can change without a read-modify-write.

The block has no streaming data path. Every pin on it is a plain control or status signal, so there is no valid/ready handshake and no back-pressure.

Top module: `gpio16_bank`

## Requirements
- R1: After reset, interrupt enable, wakeup enable, data-out, pending status and both trigger registers are 0. Direction is 0xFFFF (all pins inputs), `pin_oe` is 0, and `irq` and `wake` are low.
- R2: Plain registers read back their value in bits 15:0 with the upper bits 0. Configuration (0x10) is an 8-bit read/write register. Each alias offset reads back the value of its target register.
- R3: Data-out (0x30), interrupt enable (0x1C) and wakeup enable (0x28) take a full write. Each 1 bit written to a set alias (0xF0, 0xDC, 0xE8) sets that bit, and each 1 bit written to a clear alias (0xB0, 0x9C, 0xA8) clears it. A 0 bit leaves the target bit unchanged.
- R4: In the direction register (0x34), a bit of 1 makes the pin an input and a bit of 0 makes it an output. `pin_oe` is the inverse of direction and `pin_out` equals data-out. Both follow a write on the next clock.
- R5: Data-in (0x2C) shows `pin_in` delayed by two clock edges. Writes to data-in are ignored.
- R6: The trigger field for pin p is in register 0x38 when p bit 3 is 0 and in 0x3C when it is 1, at bits 2*(p&7)+1 and 2*(p&7). Field bit 0 enables falling-edge detection and field bit 1 enables rising-edge detection. A field of 00 detects nothing and 11 detects both edges.
- R7: A qualifying edge sets the pin's pending bit (0x18) at the third rising clock edge after `pin_in` changes. This happens whatever the enable registers hold.
- R8: Writing 1 to a bit of 0x18 clears that pending bit, and 0 bits have no effect. If a new edge arrives in the same cycle as the clear, the bit stays set.
- R9: `irq` is high exactly when some pin has both its pending bit and its interrupt enable bit set.
- R10: `wake` is high exactly when some pin has both its pending bit and its wakeup enable bit set.
- R11: The revision register (0x00) reads major version 2 in bits 7:4 and minor version 1 in bits 3:0. System status (0x14) reads 1 in bit 0 once reset is over. Both registers ignore writes.
- R12: A read from any offset not listed above returns 0, and a write to such an offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Asynchronous pin input levels |
| pin_out | output | 16 | Output values for the pins |
| pin_oe | output | 16 | Output enable for each pin, 1 = drive |
| irq | output | 1 | Combined enabled interrupt |
| wake | output | 1 | Combined wakeup request |

## Verification
The checker module covers the properties that hold on every cycle:
- the write-1 set and clear semantics on data-out;
- data-out holding its value when no write to it occurs;
- `pin_oe` following a direction write;
- `irq` and `wake` dropping once their enables are cleared;
- unmapped offsets and the upper revision bits reading 0.

The bench scenarios show what a single-cycle property cannot:
- the three-edge latency from a pin change to its pending bit, and the two-edge data-in latency;
- the packing of the per-pin trigger fields;
- a pending bit surviving a clear that lands in its own set cycle;
- pending bits latching while interrupts are disabled.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;

  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_VER      = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG      = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SST      = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_PEND     = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_IEN      = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_WKEN     = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_DIN      = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_DOUT     = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_DIR      = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_TRLO     = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_TRHI     = 8'h3C;
  localparam logic [ADDR_W-1:0] OFS_IEN_CLR  = 8'h9C;
  localparam logic [ADDR_W-1:0] OFS_WKEN_CLR = 8'hA8;
  localparam logic [ADDR_W-1:0] OFS_DOUT_CLR = 8'hB0;
  localparam logic [ADDR_W-1:0] OFS_IEN_SET  = 8'hDC;
  localparam logic [ADDR_W-1:0] OFS_WKEN_SET = 8'hE8;
  localparam logic [ADDR_W-1:0] OFS_DOUT_SET = 8'hF0;

  // per-pin trigger field: bit0 = falling, bit1 = rising
  typedef enum logic [1:0] {
    TRIG_NONE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_BOTH = 2'b11
  } trig_e;

  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_VER, OFS_CFG, OFS_SST, OFS_PEND, OFS_IEN, OFS_WKEN, OFS_DIN,
      OFS_DOUT, OFS_DIR, OFS_TRLO, OFS_TRHI, OFS_IEN_CLR, OFS_WKEN_CLR,
      OFS_DOUT_CLR, OFS_IEN_SET, OFS_WKEN_SET, OFS_DOUT_SET: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio16_sync.sv
module gpio16_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio16_edge.sv
module gpio16_edge
  import gpio16_pkg::*;
#(
  parameter int unsigned N_PINS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_PINS-1:0]     level,
  input  logic [2*N_PINS-1:0]   trig,
  output logic [N_PINS-1:0]     hit
);

  logic [N_PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    trig_e mode;
    logic  rise_en, fall_en, rose, fell;

    assign mode    = trig_e'(trig[2*i +: 2]);
    assign rise_en = (mode == TRIG_RISE) || (mode == TRIG_BOTH);
    assign fall_en = (mode == TRIG_FALL) || (mode == TRIG_BOTH);
    assign rose    =  level[i] & ~prev_q[i];
    assign fell    = ~level[i] &  prev_q[i];
    assign hit[i]  = (rise_en & rose) | (fall_en & fell);
  end

endmodule

// File: rtl/gpio16_regs.sv
module gpio16_regs
  import gpio16_pkg::*;
#(
  parameter int unsigned N_PINS    = 16,
  parameter int unsigned CFG_W     = 8,
  parameter int unsigned VER_MAJOR = 2,
  parameter int unsigned VER_MINOR = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [N_PINS-1:0]   hit,
  input  logic [N_PINS-1:0]   din,
  output logic [DATA_W-1:0]   rdata,
  output logic [N_PINS-1:0]   dir_q,
  output logic [N_PINS-1:0]   dout_q,
  output logic [N_PINS-1:0]   ien_q,
  output logic [N_PINS-1:0]   wken_q,
  output logic [N_PINS-1:0]   pend_q,
  output logic [2*N_PINS-1:0] trig_q
);

  localparam int unsigned HALF = N_PINS / 2;
  localparam int unsigned TW   = 2 * HALF;
  localparam logic [7:0]  VER_BYTE = {4'(VER_MAJOR), 4'(VER_MINOR)};

  logic [TW-1:0]     trlo_q, trhi_q;
  logic [CFG_W-1:0]  cfg_q;
  logic              ready_q;
  logic [N_PINS-1:0] wbits;
  logic [N_PINS-1:0] pend_clr;
  logic              wdata_unused;

  assign wbits        = wdata[N_PINS-1:0];
  assign wdata_unused = ^wdata[DATA_W-1:N_PINS];
  assign pend_clr     = (wr_en && addr == OFS_PEND) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '1;
      dout_q  <= '0;
      ien_q   <= '0;
      wken_q  <= '0;
      pend_q  <= '0;
      trlo_q  <= '0;
      trhi_q  <= '0;
      cfg_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      // a fresh edge outranks a same-cycle clear
      pend_q  <= (pend_q & ~pend_clr) | hit;
      if (wr_en) begin
        case (addr)
          OFS_CFG:      cfg_q  <= wdata[CFG_W-1:0];
          OFS_IEN:      ien_q  <= wbits;
          OFS_IEN_SET:  ien_q  <= ien_q | wbits;
          OFS_IEN_CLR:  ien_q  <= ien_q & ~wbits;
          OFS_WKEN:     wken_q <= wbits;
          OFS_WKEN_SET: wken_q <= wken_q | wbits;
          OFS_WKEN_CLR: wken_q <= wken_q & ~wbits;
          OFS_DOUT:     dout_q <= wbits;
          OFS_DOUT_SET: dout_q <= dout_q | wbits;
          OFS_DOUT_CLR: dout_q <= dout_q & ~wbits;
          OFS_DIR:      dir_q  <= wbits;
          OFS_TRLO:     trlo_q <= wdata[TW-1:0];
          OFS_TRHI:     trhi_q <= wdata[TW-1:0];
          default: ;
        endcase
      end
    end
  end

  assign trig_q = {trhi_q, trlo_q};

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_VER:                             rdata[7:0]        = VER_BYTE;
      OFS_CFG:                             rdata[CFG_W-1:0]  = cfg_q;
      OFS_SST:                             rdata[0]          = ready_q;
      OFS_PEND:                            rdata[N_PINS-1:0] = pend_q;
      OFS_IEN, OFS_IEN_SET, OFS_IEN_CLR:   rdata[N_PINS-1:0] = ien_q;
      OFS_WKEN, OFS_WKEN_SET, OFS_WKEN_CLR: rdata[N_PINS-1:0] = wken_q;
      OFS_DIN:                             rdata[N_PINS-1:0] = din;
      OFS_DOUT, OFS_DOUT_SET, OFS_DOUT_CLR: rdata[N_PINS-1:0] = dout_q;
      OFS_DIR:                             rdata[N_PINS-1:0] = dir_q;
      OFS_TRLO:                            rdata[TW-1:0]     = trlo_q;
      OFS_TRHI:                            rdata[TW-1:0]     = trhi_q;
      default:                             rdata             = '0;
    endcase
  end

endmodule

// File: rtl/gpio16_bank.sv
module gpio16_bank
  import gpio16_pkg::*;
#(
  parameter int unsigned N_PINS      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CFG_W       = 8,
  parameter int unsigned VER_MAJOR   = 2,
  parameter int unsigned VER_MINOR   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic              irq,
  output logic              wake
);

  logic [N_PINS-1:0]   pin_lvl;
  logic [N_PINS-1:0]   hit;
  logic [N_PINS-1:0]   dir, dout, ien, wken, pend;
  logic [2*N_PINS-1:0] trig;

  gpio16_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_lvl)
  );

  gpio16_edge #(.N_PINS(N_PINS)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (pin_lvl),
    .trig  (trig),
    .hit   (hit)
  );

  gpio16_regs #(
    .N_PINS(N_PINS), .CFG_W(CFG_W), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .hit    (hit),
    .din    (pin_lvl),
    .rdata  (bus_rdata),
    .dir_q  (dir),
    .dout_q (dout),
    .ien_q  (ien),
    .wken_q (wken),
    .pend_q (pend),
    .trig_q (trig)
  );

  assign pin_out = dout;
  assign pin_oe  = ~dir;
  assign irq     = |(pend & ien);
  assign wake    = |(pend & wken);

endmodule

// File: rtl/gpio16_bank_chk.sv
module gpio16_bank_chk
  import gpio16_pkg::*;
#(
  parameter int unsigned N_PINS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [N_PINS-1:0] pin_out,
  input logic [N_PINS-1:0] pin_oe,
  input logic              irq,
  input logic              wake
);

  logic dout_touch;
  assign dout_touch = bus_wr && (bus_addr == OFS_DOUT || bus_addr == OFS_DOUT_SET ||
                                 bus_addr == OFS_DOUT_CLR);

  p_dir_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DIR) |=> (pin_oe == ~$past(bus_wdata[N_PINS-1:0])));

  p_dout_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DOUT_SET) |=>
      (pin_out == ($past(pin_out) | $past(bus_wdata[N_PINS-1:0]))));

  p_dout_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DOUT_CLR) |=>
      (pin_out == ($past(pin_out) & ~$past(bus_wdata[N_PINS-1:0]))));

  p_dout_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_touch |=> $stable(pin_out));

  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_IEN_CLR && (&bus_wdata[N_PINS-1:0])) |=> !irq);

  p_irq_zero_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_IEN && bus_wdata[N_PINS-1:0] == '0) |=> !irq);

  p_wake_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_WKEN_CLR && (&bus_wdata[N_PINS-1:0])) |=> !wake);

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mapped(bus_addr) |-> (bus_rdata == 32'h0));

  p_ver_upper_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_VER) |-> (bus_rdata[31:8] == 24'h0));

endmodule

bind gpio16_bank gpio16_bank_chk #(.N_PINS(N_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .wake      (wake)
);

// File: tb/test_gpio16_bank.sv
module test_gpio16_bank;
  import gpio16_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq, wake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // requirement-level model
  logic [15:0] m_dir, m_dout, m_ien, m_wken, m_pend, m_trlo, m_trhi, m_pins;
  logic [7:0]  m_cfg;

  always #5 clk = ~clk;

  gpio16_bank i_gpio16_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .wake(wake)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  // R6: pin p field is in low reg when p<8, bits 2*(p&7)+:2; bit0 fall, bit1 rise
  function automatic logic [15:0] exp_hit(input logic [15:0] oldv, input logic [15:0] newv,
                                          input logic [15:0] lo, input logic [15:0] hi);
    logic [15:0] r = '0;
    for (int p = 0; p < 16; p++) begin
      logic [1:0] f = (p < 8) ? lo[2*p +: 2] : hi[2*(p-8) +: 2];
      if (f[1] && !oldv[p] && newv[p]) r[p] = 1'b1;
      if (f[0] && oldv[p] && !newv[p]) r[p] = 1'b1;
    end
    return r;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      OFS_CFG:      m_cfg  = d[7:0];
      OFS_IEN:      m_ien  = d[15:0];
      OFS_IEN_SET:  m_ien  = m_ien | d[15:0];
      OFS_IEN_CLR:  m_ien  = m_ien & ~d[15:0];
      OFS_WKEN:     m_wken = d[15:0];
      OFS_WKEN_SET: m_wken = m_wken | d[15:0];
      OFS_WKEN_CLR: m_wken = m_wken & ~d[15:0];
      OFS_DOUT:     m_dout = d[15:0];
      OFS_DOUT_SET: m_dout = m_dout | d[15:0];
      OFS_DOUT_CLR: m_dout = m_dout & ~d[15:0];
      OFS_DIR:      m_dir  = d[15:0];
      OFS_TRLO:     m_trlo = d[15:0];
      OFS_TRHI:     m_trhi = d[15:0];
      OFS_PEND:     m_pend = m_pend & ~d[15:0];
      default: ;
    endcase
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic set_pins(input logic [15:0] v);
    logic [15:0] h;
    h = exp_hit(m_pins, v, m_trlo, m_trhi);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
    m_pins = v;
    m_pend = m_pend | h;
  endtask

  task automatic verify_all();
    logic [31:0] v;
    rd(OFS_VER, v);      check("R11 revision", v, 32'h21);
    rd(OFS_SST, v);      check("R11 sysstatus", v, 32'h1);
    rd(OFS_CFG, v);      check("R2 config", v, {24'h0, m_cfg});
    rd(OFS_PEND, v);     check("R7 pending", v, {16'h0, m_pend});
    rd(OFS_IEN, v);      check("R3 int enable", v, {16'h0, m_ien});
    rd(OFS_WKEN_SET, v); check("R2 wake alias read", v, {16'h0, m_wken});
    rd(OFS_DIN, v);      check("R5 data-in", v, {16'h0, m_pins});
    rd(OFS_DOUT_CLR, v); check("R2 dout alias read", v, {16'h0, m_dout});
    rd(OFS_DIR, v);      check("R4 direction", v, {16'h0, m_dir});
    rd(OFS_TRLO, v);     check("R6 trig low", v, {16'h0, m_trlo});
    rd(OFS_TRHI, v);     check("R6 trig high", v, {16'h0, m_trhi});
    check("R4 pin_out", {16'h0, pin_out}, {16'h0, m_dout});
    check("R4 pin_oe", {16'h0, pin_oe}, {16'h0, ~m_dir});
    check("R9 irq", {31'h0, irq}, {31'h0, |(m_pend & m_ien)});
    check("R10 wake", {31'h0, wake}, {31'h0, |(m_pend & m_wken)});
  endtask

  function automatic logic [7:0] pick_addr(input int unsigned k);
    case (k % 20)
      0: return OFS_CFG;      1: return OFS_IEN;      2: return OFS_IEN_SET;
      3: return OFS_IEN_CLR;  4: return OFS_WKEN;     5: return OFS_WKEN_SET;
      6: return OFS_WKEN_CLR; 7: return OFS_DOUT;     8: return OFS_DOUT_SET;
      9: return OFS_DOUT_CLR; 10: return OFS_DIR;     11: return OFS_TRLO;
      12: return OFS_TRHI;    13: return OFS_PEND;    14: return OFS_VER;
      15: return OFS_SST;     16: return OFS_DIN;     17: return 8'h04;
      18: return 8'h40;       default: return 8'hFC;
    endcase
  endfunction

  initial begin
    repeat (5000 * 30) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1234_5EED));
    m_dir = 16'hFFFF; m_dout = '0; m_ien = '0; m_wken = '0; m_pend = '0;
    m_trlo = '0; m_trhi = '0; m_pins = '0; m_cfg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq low", {31'h0, irq}, 32'h0);
    check("R1 wake low", {31'h0, wake}, 32'h0);
    check("R1 pin_oe zero", {16'h0, pin_oe}, 32'h0);
    rd(OFS_IEN, v);  check("R1 int enable zero", v, 32'h0);
    rd(OFS_WKEN, v); check("R1 wake enable zero", v, 32'h0);
    rd(OFS_DIR, v);  check("R1 direction all inputs", v, 32'hFFFF);
    verify_all();

    // R12 / R11 unmapped and read-only offsets
    rd(8'h04, v); check("R12 unmapped read", v, 32'h0);
    rd(8'hFC, v); check("R12 unmapped read high", v, 32'h0);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(OFS_VER, 32'hFFFF_FFFF);
    wr(OFS_SST, 32'h0);
    wr(OFS_DIN, 32'hFFFF);
    verify_all();

    // R5/R7/R9 exact latency, pin 0 rising
    wr(OFS_TRLO, 32'h2);
    wr(OFS_IEN, 32'h1);
    @(negedge clk);
    bus_addr = OFS_DIN;
    pin_in = 16'h0001;
    @(negedge clk); #1;
    check("R5 din after one edge", {31'h0, bus_rdata[0]}, 32'h0);
    check("R7 no status after one edge", {31'h0, irq}, 32'h0);
    @(negedge clk); #1;
    check("R5 din after two edges", {31'h0, bus_rdata[0]}, 32'h1);
    check("R7 no status after two edges", {31'h0, irq}, 32'h0);
    @(negedge clk); #1;
    check("R7 R9 status after three edges", {31'h0, irq}, 32'h1);
    m_pins = 16'h0001; m_pend = 16'h0001;
    verify_all();

    // R8 write-1 clear then set-wins-over-clear
    wr(OFS_PEND, 32'h0000_FFFE);
    rd(OFS_PEND, v); check("R8 zero bits keep pending", v, 32'h1);
    wr(OFS_PEND, 32'h1);
    rd(OFS_PEND, v); check("R8 clear by writing one", v, 32'h0);
    wr(OFS_TRLO, 32'h3);
    @(negedge clk); pin_in = 16'h0000;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = OFS_PEND; bus_wdata = 32'h1;
    @(negedge clk); bus_wr = 1'b0;
    m_pins = 16'h0000; m_pend = 16'h0001;
    rd(OFS_PEND, v); check("R8 edge beats same-cycle clear", v, 32'h1);
    wr(OFS_PEND, 32'hFFFF);

    // R6 high register packing: pin8 falling only, pin9 rising only
    wr(OFS_TRHI, 32'h0000_0009);
    set_pins(16'h0300);
    rd(OFS_PEND, v); check("R6 pin9 rise, pin8 no rise", v & 32'h300, 32'h200);
    set_pins(16'h0000);
    rd(OFS_PEND, v); check("R6 pin8 fall, pin9 no fall", v & 32'h300, 32'h300);
    // R7 status latched with interrupts disabled, R10 wake path
    wr(OFS_IEN, 32'h0);
    check("R9 irq low with no enables", {31'h0, irq}, 32'h0);
    wr(OFS_WKEN_SET, 32'h0100);
    check("R10 wake from pin8", {31'h0, wake}, 32'h1);
    wr(OFS_WKEN_CLR, 32'hFFFF);
    check("R10 wake dropped", {31'h0, wake}, 32'h0);
    verify_all();

    // random mix
    for (int it = 0; it < 400; it++) begin
      int unsigned op = $urandom % 6;
      case (op)
        0, 1: wr(pick_addr($urandom), $urandom);
        2, 3: set_pins(16'($urandom));
        4: wr(OFS_PEND, {16'h0, 16'($urandom)});
        default: wr(($urandom % 2) ? OFS_TRLO : OFS_TRHI, $urandom);
      endcase
      verify_all();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule